// File: doc/BRIEF.md
# Cascadable Dual-Channel Pulse Generator

This block generates square-ish pulse trains from two 8-bit down-counter channels. Each channel holds two reload bytes. One byte sets how many ticks the output stays low, and the other sets how many ticks it stays high. A channel counts down once per enabled `tick`. When a channel passes zero it flips its phase and loads the byte for the new phase. The result is a waveform whose low time is `lo+1` ticks and whose high time is `hi+1` ticks.

A mode bit joins the two channels into one 16-bit down counter. Channel 0 is the low byte and channel 1 is the high byte. In this cascaded mode:
- Both channels reload together.
- Both underflow flags are raised in the same cycle.
- Both output pins carry one common waveform.

A single write can clear both flags, so the flags never disagree. The interrupt line is the OR of every flag that has its enable set.

Configuration arrives over a simple write port with a 3-bit address and a byte of data.

Top module: `ppg_cascade_timer`

## Requirements
- R1: In independent mode (address 0 bit 4 = 0), a channel whose run bit (ctrl bit 0) is set drives its pin low for lo+1 ticks and then high for hi+1 ticks, repeating. Its pin is high only when its pin-enable bit (ctrl bit 1) is set. Control for channel 0 is at address 0 and for channel 1 at address 1. The reload bytes are at addresses 2 (ch0 lo), 3 (ch0 hi), 4 (ch1 lo) and 5 (ch1 hi).
- R2: In cascaded mode, the pair counts as one 16-bit value {ch1, ch0}. The low phase lasts {lo1,lo0}+1 ticks and the high phase lasts {hi1,hi0}+1 ticks.
- R3: In cascaded mode, both pins show the same waveform whenever either channel's pin-enable bit is set. Both pins stay low when neither is set.
- R4: In cascaded mode, counting happens only while both run bits are set. Otherwise the counter holds its start value and both pins are low. After reset all outputs are low.
- R5: At a cascaded underflow, both channels load their reload bytes in the same clock cycle.
- R6: At a cascaded underflow, both underflow flags (uf_flag) rise in the same cycle.
- R7: irq is high exactly while some flag is set whose channel's interrupt-enable bit (ctrl bit 2) is set.
- R8: Flags clear in three ways:
  - Writing 1 to ctrl bit 3 clears that channel's flag.
  - Writing address 6 clears flag 0 with data bit 0 and flag 1 with data bit 1.
  - In cascaded mode, any clear request clears both flags.
- R9: An underflow and a clear in the same cycle leave the flag set.
- R10: A reload byte written during a phase changes nothing until the next underflow loads it.
- R11: In independent mode, each channel sets its own flag only on its own underflow.
- R12: Counting advances only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pin_out | output | 2 | Pulse outputs of channel 0 and 1 |
| irq | output | 1 | Combined interrupt request |
| uf_flag | output | 2 | Underflow flags of channel 0 and 1 |

## Verification
Any corrupted counter or phase bit shows up at the pins no later than the next underflow: an edge arrives early, arrives late, or differs between the two pins in cascaded mode. A flag that should be mirrored but is not shows as an uf_flag mismatch in the cycle after the underflow. A wrong set-versus-clear priority shows in the same cycle, because a clear held every cycle would otherwise hide that underflow. A stale reload value appears as a wrong phase length one full phase after the write, so the compared stretches span several complete periods.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0   = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1   = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;

  localparam int B_RUN  = 0;
  localparam int B_PE   = 1;
  localparam int B_IE   = 2;
  localparam int B_CLR  = 3;
  localparam int B_CASC = 4;

  typedef struct packed {
    logic run;
    logic pe;
    logic ie;
  } ch_cfg_t;

  // Value the phase that starts after an underflow begins with.
  function automatic logic [7:0] pick_reload(input logic cur_phase,
                                             input logic [7:0] lo,
                                             input logic [7:0] hi);
    return cur_phase ? lo : hi;
  endfunction

  // Clear requests widen to both channels in cascaded mode.
  function automatic logic [1:0] spread_clear(input logic casc, input logic [1:0] req);
    return casc ? {2{|req}} : req;
  endfunction
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int CW = 8,
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CW-1:0]         wr_data,
  input  logic [NCH-1:0]        uf_set,
  output ch_cfg_t [NCH-1:0]     cfg,
  output logic                  casc,
  output logic [NCH-1:0][CW-1:0] rld_lo,
  output logic [NCH-1:0][CW-1:0] rld_hi,
  output logic [NCH-1:0]        flag
);
  logic [NCH-1:0] clr_req;
  logic [NCH-1:0] clr_eff;

  always_comb begin
    clr_req = '0;
    if (wr_en) begin
      if (wr_addr == A_CTRL0) clr_req[0] = wr_data[B_CLR];
      if (wr_addr == A_CTRL1) clr_req[1] = wr_data[B_CLR];
      if (wr_addr == A_CLR)   clr_req    = wr_data[NCH-1:0];
    end
    clr_eff = spread_clear(casc, clr_req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) casc <= 1'b0;
    else if (wr_en && wr_addr == A_CTRL0) casc <= wr_data[B_CASC];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CADR = (i == 0) ? A_CTRL0 : A_CTRL1;
    localparam logic [ADDR_W-1:0] LADR = (i == 0) ? A_LO0 : A_LO1;
    localparam logic [ADDR_W-1:0] HADR = (i == 0) ? A_HI0 : A_HI1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i]    <= '0;
        rld_lo[i] <= '0;
        rld_hi[i] <= '0;
        flag[i]   <= 1'b0;
      end else begin
        if (wr_en && wr_addr == CADR) begin
          cfg[i].run <= wr_data[B_RUN];
          cfg[i].pe  <= wr_data[B_PE];
          cfg[i].ie  <= wr_data[B_IE];
        end
        if (wr_en && wr_addr == LADR) rld_lo[i] <= wr_data;
        if (wr_en && wr_addr == HADR) rld_hi[i] <= wr_data;
        flag[i] <= uf_set[i] | (flag[i] & ~clr_eff[i]);
      end
    end
  end
endmodule

// File: rtl/ppg_chan.sv
module ppg_chan
  import ppg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          dec,
  input  logic          uf_evt,
  input  logic [CW-1:0] rld_lo,
  input  logic [CW-1:0] rld_hi,
  output logic [CW-1:0] cnt,
  output logic          phase,
  output logic          zero
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (idle) begin
      cnt   <= rld_lo;
      phase <= 1'b0;
    end else if (uf_evt) begin
      cnt   <= pick_reload(phase, rld_lo, rld_hi);
      phase <= ~phase;
    end else if (dec) begin
      cnt   <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ppg_cascade_timer.sv
module ppg_cascade_timer
  import ppg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [1:0]        pin_out,
  output logic              irq,
  output logic [1:0]        uf_flag
);
  localparam int NCH = 2;

  ch_cfg_t [NCH-1:0]      cfg;
  logic                   casc_q;
  logic [NCH-1:0][CW-1:0] rld_lo, rld_hi;
  logic [NCH-1:0]         flag;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [NCH-1:0]         phase, zero;
  logic [NCH-1:0]         idle, dec, uf_evt;
  logic                   casc_act, casc_uf;
  logic [2*CW-1:0]        cnt16;

  ppg_regs #(.CW(CW), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uf_set(uf_evt), .cfg(cfg), .casc(casc_q), .rld_lo(rld_lo), .rld_hi(rld_hi),
    .flag(flag)
  );

  assign casc_act = casc_q & cfg[0].run & cfg[1].run;
  assign casc_uf  = casc_act & tick & zero[0] & zero[1];
  assign cnt16    = {cnt[1], cnt[0]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (casc_q) begin
        idle[i]   = ~casc_act;
        dec[i]    = casc_act & tick & ((i == 0) ? 1'b1 : zero[0]);
        uf_evt[i] = casc_uf;
      end else begin
        idle[i]   = ~cfg[i].run;
        dec[i]    = cfg[i].run & tick;
        uf_evt[i] = cfg[i].run & tick & zero[i];
      end
    end

    ppg_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .idle(idle[i]), .dec(dec[i]), .uf_evt(uf_evt[i]),
      .rld_lo(rld_lo[i]), .rld_hi(rld_hi[i]), .cnt(cnt[i]), .phase(phase[i]),
      .zero(zero[i])
    );

    assign pin_out[i] = casc_q ? (casc_act & phase[1] & (cfg[0].pe | cfg[1].pe))
                               : (cfg[i].run & cfg[i].pe & phase[i]);
  end

  assign irq     = |(flag & {cfg[1].ie, cfg[0].ie});
  assign uf_flag = flag;
endmodule

// File: rtl/ppg_cascade_timer_chk.sv
module ppg_cascade_timer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [1:0]    pin_out,
  input logic          irq,
  input logic [1:0]    uf_flag,
  input logic          casc,
  input logic          act_casc,
  input logic [1:0]    uf_evt,
  input logic [2*CW-1:0] cnt16
);
  AST_CASC_PINS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    casc |-> pin_out[0] == pin_out[1]);  // R3
  AST_CASC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !act_casc) |-> pin_out == 2'b00);  // R4
  AST_CASC_FLAGS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && uf_evt[0]) |=> uf_flag == 2'b11);  // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt[1] |=> uf_flag[1]);  // R9
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    uf_flag == 2'b00 |-> !irq);  // R7
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_casc && !tick && !wr_en) |=> $stable(cnt16));  // R12
  AST_OWN_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && !uf_evt[1] && !uf_flag[1]) |=> !uf_flag[1]);  // R11
endmodule

bind ppg_cascade_timer ppg_cascade_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .pin_out(pin_out),
  .irq(irq), .uf_flag(uf_flag), .casc(casc_q), .act_casc(casc_act),
  .uf_evt(uf_evt), .cnt16(cnt16)
);

// File: tb/tb_ppg_cascade_timer.sv
module tb_ppg_cascade_timer;
  localparam int CW = 8;
  localparam int BASE = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0] pin_out;
  logic irq;
  logic [1:0] uf_flag;

  int n_cmp = 0, n_bad = 0, cyc = 0, tcnt = 0;
  bit slow_tick = 0;
  bit done = 0;
  string req = "R4 reset";

  always #10 clk = ~clk;

  ppg_cascade_timer #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_out(pin_out), .irq(irq), .uf_flag(uf_flag)
  );

  // Behavioural reference
  int m_run[2], m_pe[2], m_ie[2], m_flag[2], m_lo[2], m_hi[2];
  int m_ph[2], m_cnt[2], m_casc, m_cph, m_cc;

  always @(posedge clk) begin
    int uf[2];
    int clr[2];
    uf[0] = 0; uf[1] = 0;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_run[i] = 0; m_pe[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
        m_lo[i] = 0; m_hi[i] = 0; m_ph[i] = 0; m_cnt[i] = 0;
      end
      m_casc = 0; m_cph = 0; m_cc = 0;
    end else begin
      if (m_casc != 0) begin
        if (!(m_run[0] != 0 && m_run[1] != 0)) begin
          m_cc = m_lo[1] * BASE + m_lo[0]; m_cph = 0;
        end else if (tick) begin
          if (m_cc == 0) begin
            m_cph = 1 - m_cph;
            m_cc = m_cph != 0 ? m_hi[1] * BASE + m_hi[0] : m_lo[1] * BASE + m_lo[0];
            uf[0] = 1; uf[1] = 1;
          end else m_cc = m_cc - 1;
        end
        m_ph[0] = m_cph; m_ph[1] = m_cph;
        m_cnt[0] = m_cc % BASE; m_cnt[1] = m_cc / BASE;
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (m_run[i] == 0) begin
            m_cnt[i] = m_lo[i]; m_ph[i] = 0;
          end else if (tick) begin
            if (m_cnt[i] == 0) begin
              m_ph[i] = 1 - m_ph[i];
              m_cnt[i] = m_ph[i] != 0 ? m_hi[i] : m_lo[i];
              uf[i] = 1;
            end else m_cnt[i] = m_cnt[i] - 1;
          end
        end
        m_cc = m_cnt[1] * BASE + m_cnt[0]; m_cph = m_ph[1];
      end
      clr[0] = 0; clr[1] = 0;
      if (wr_en) begin
        if (wr_addr == 0) clr[0] = wr_data[3];
        if (wr_addr == 1) clr[1] = wr_data[3];
        if (wr_addr == 6) begin clr[0] = wr_data[0]; clr[1] = wr_data[1]; end
      end
      if (m_casc != 0 && (clr[0] != 0 || clr[1] != 0)) begin clr[0] = 1; clr[1] = 1; end
      for (int i = 0; i < 2; i++)
        m_flag[i] = (uf[i] != 0 || (m_flag[i] != 0 && clr[i] == 0)) ? 1 : 0;
      if (wr_en) begin
        case (wr_addr)
          0: begin m_run[0] = wr_data[0]; m_pe[0] = wr_data[1]; m_ie[0] = wr_data[2];
                   m_casc = wr_data[4]; end
          1: begin m_run[1] = wr_data[0]; m_pe[1] = wr_data[1]; m_ie[1] = wr_data[2]; end
          2: m_lo[0] = wr_data;
          3: m_hi[0] = wr_data;
          4: m_lo[1] = wr_data;
          5: m_hi[1] = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [1:0] exp_pins();
    logic [1:0] p;
    if (m_casc != 0) begin
      p[0] = (m_run[0] != 0 && m_run[1] != 0 && m_cph != 0 && (m_pe[0] != 0 || m_pe[1] != 0));
      p[1] = p[0];
    end else begin
      for (int i = 0; i < 2; i++) p[i] = (m_run[i] != 0 && m_pe[i] != 0 && m_ph[i] != 0);
    end
    return p;
  endfunction

  task automatic check(input string what, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("pins", pin_out, exp_pins());
      check("irq", {1'b0, irq},
            {1'b0, ((m_flag[0] != 0 && m_ie[0] != 0) || (m_flag[1] != 0 && m_ie[1] != 0))});
      check("flags", uf_flag, {m_flag[1] != 0, m_flag[0] != 0});
    end
  end

  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    tick <= slow_tick ? (tcnt % 3 == 0) : 1'b1;
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(3);

    // R1 R11 R7: independent channels with different periods
    req = "R1 R11 R7 independent";
    wr(2, 2); wr(3, 3); wr(4, 1); wr(5, 0);
    wr(0, 8'b0_0111);
    wr(1, 8'b0_0011);
    idle_cycles(40);

    // R8: per-channel clear, R10: reload change mid-phase
    req = "R8 R10 clear and late reload";
    wr(0, 8'b0_1111);
    wr(2, 5);
    idle_cycles(10);
    wr(6, 2'b11);
    idle_cycles(30);

    // R12: sparse ticks
    req = "R12 tick gating";
    slow_tick = 1;
    idle_cycles(40);
    slow_tick = 0;

    wr(0, 0); wr(1, 0);
    idle_cycles(3);

    // R4: cascade with a single run bit holds still
    req = "R4 cascade partial run";
    wr(2, 3); wr(4, 1); wr(3, 2); wr(5, 0);
    wr(0, 8'b1_0111);
    idle_cycles(20);

    // R2 R3 R5 R6: full cascade, only ch0 pin-enable
    req = "R2 R3 R5 R6 cascade";
    wr(1, 8'b0_0001);
    idle_cycles(600);

    // R9 R8: joint clear held every cycle across underflows
    req = "R9 R8 joint clear";
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = CW'(1);
    idle_cycles(300);
    wr_en = 1'b0;
    idle_cycles(280);

    // R8: clear through channel 1 control clears both in cascade
    req = "R8 cascade ctrl clear";
    wr(1, 8'b0_1001);
    idle_cycles(20);

    // R3: neither pin enabled, R10: new cascade reload
    req = "R3 R10 cascade no pins";
    wr(0, 8'b1_0101);
    wr(2, 0); wr(4, 0);
    idle_cycles(300);

    // R4: stop both runs
    req = "R4 cascade stop";
    wr(0, 8'b1_0000); wr(1, 0);
    idle_cycles(20);

    finish_run();
  end
endmodule